// File: doc/BRIEF.md
# Paired Even/Odd Row Scan Sequencer

This block produces the fetch order for a square frame whose side is a power of two, so that two row filters working side by side each get one pixel per clock. On every active cycle it drives two addresses at once: one into an even row and one into the odd row directly below it, both at the same column. Within one pair of rows the column steps by one per clock. When the last column is reached the scan moves down to the next pair of rows. Markers for the first and last column of each row go out with the addresses. The filters downstream use them to mirror samples at the row edges.

A frame can cover several decomposition levels. After the first level, which reads the source image, each later level re-reads the stored low-low quarter of the level before it. That quarter is addressed row-major with its own side, which is half the previous one. A short idle gap between levels gives the previous results time to land in storage. The number of levels is set by a minimum side length, captured when the frame starts. When no further level is allowed, a one-cycle completion pulse is issued.

Top module: `pairscan_ctrl`

## Requirements
- R1: After reset, pix_valid, busy and frame_done are all 0.
- R2: A start pulse seen while idle produces the first beat on the next cycle: level 0, column 0, row pair 0, even address 0 and odd address equal to SIDE_MAX.
- R3: For a level of side S, a beat at row pair p and column c drives even_addr = 2·p·S + c and odd_addr = even_addr + S in the same cycle.
- R4: Within a level, beats are issued column 0 to S−1 for row pair 0, then for row pair 1, and so on, with one beat per clock and no idle cycles.
- R5: row_first is 1 exactly on beats at column 0, and row_last is 1 exactly on beats at column S−1.
- R6: A level of side S lasts exactly S²/2 consecutive beats, and pix_valid is never 1 while busy is 0.
- R7: When another level follows, exactly LEVEL_GAP cycles with pix_valid 0 and busy 1 come before its first beat. That level uses side S/2 and cur_level one higher. from_ll is 1 on every level except level 0.
- R8: A further level runs only if S/2 is at least the captured minimum and at least 2. Otherwise, on the cycle after the last beat, frame_done is 1 for exactly one cycle, with busy and pix_valid both 0.
- R9: A start pulse while busy has no effect on the ongoing sequence.
- R10: min_side is captured only when the frame starts, so changes to it during a frame do not change the number of levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a frame when idle |
| min_side | input | log2(SIDE_MAX)+1 | Smallest side length a level may have |
| pix_valid | output | 1 | Both addresses are valid this cycle |
| even_addr | output | 2·log2(SIDE_MAX) | Address of the even-row pixel |
| odd_addr | output | 2·log2(SIDE_MAX) | Address of the odd-row pixel at the same column |
| row_first | output | 1 | Beat is at the first column |
| row_last | output | 1 | Beat is at the last column |
| cur_level | output | clog2(log2(SIDE_MAX)+1) | Current decomposition level |
| from_ll | output | 1 | Source is the stored low-low quarter, not the image |
| busy | output | 1 | A frame is in progress |
| frame_done | output | 1 | One-cycle pulse after the final beat |

## Verification
The first beat is due in the cycle after the clock edge that samples start. After that, one beat is due on every clock until the level ends, then exactly LEVEL_GAP empty cycles, and the completion pulse comes in the cycle right after the final beat. The bench changes inputs and samples outputs only on falling edges. It walks a model of row pairs and columns forward one step per falling edge, so each expected beat is compared in exactly the cycle it is due. Start pulses and min_side changes injected during a frame leave that model unchanged, which checks that they are ignored.

// File: rtl/pairscan_pkg.sv
package pairscan_pkg;

    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_SCAN = 2'd1,
        PS_GAP  = 2'd2
    } ps_state_e;

endpackage

// File: rtl/pairscan_pos.sv
// Column / row-pair position counter for one decomposition level.
module pairscan_pos #(
    parameter int LOG_MAX = 8,
    localparam int LW     = $clog2(LOG_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               adv,
    input  logic [LW-1:0]      side_log,
    output logic [LOG_MAX-1:0] col,
    output logic [LOG_MAX-2:0] pair,
    output logic               first_col,
    output logic               last_col,
    output logic               last_beat
);

    typedef struct packed {
        logic [LOG_MAX-1:0] col;
        logic [LOG_MAX-2:0] pair;
    } pos_t;

    pos_t pos_d, pos_q;

    logic [LOG_MAX:0]   side_w;
    logic [LOG_MAX-1:0] col_max;
    logic [LOG_MAX-1:0] pair_max;
    logic               last_pair;

    always_comb begin
        side_w    = (LOG_MAX+1)'(1) << side_log;
        col_max   = side_w[LOG_MAX-1:0] - LOG_MAX'(1);
        pair_max  = side_w[LOG_MAX:1] - LOG_MAX'(1);
        last_pair = ({1'b0, pos_q.pair} == pair_max);

        pos_d = pos_q;
        if (clr) begin
            pos_d = '0;
        end else if (adv) begin
            if (pos_q.col == col_max) begin
                pos_d.col  = '0;
                pos_d.pair = last_pair ? '0 : pos_q.pair + (LOG_MAX-1)'(1);
            end else begin
                pos_d.col  = pos_q.col + LOG_MAX'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else begin
            pos_q <= pos_d;
        end
    end

    assign col       = pos_q.col;
    assign pair      = pos_q.pair;
    assign first_col = (pos_q.col == '0);
    assign last_col  = (pos_q.col == col_max);
    assign last_beat = last_col && last_pair;

endmodule

// File: rtl/pairscan_addr.sv
// Row-major address pair for the current position and side length.
module pairscan_addr #(
    parameter int LOG_MAX = 8,
    localparam int LW     = $clog2(LOG_MAX + 1),
    localparam int AW     = 2 * LOG_MAX
) (
    input  logic [LOG_MAX-1:0] col,
    input  logic [LOG_MAX-2:0] pair,
    input  logic [LW-1:0]      side_log,
    output logic [AW-1:0]      even_addr,
    output logic [AW-1:0]      odd_addr
);

    logic [AW-1:0] row_base;
    logic [AW-1:0] stride;

    always_comb begin
        row_base  = AW'({pair, 1'b0}) << side_log;
        stride    = AW'(1) << side_log;
        even_addr = row_base + AW'(col);
        odd_addr  = even_addr + stride;
    end

endmodule

// File: rtl/pairscan_level.sv
// Frame / level sequencer: start capture, inter-level gap, termination.
module pairscan_level
    import pairscan_pkg::*;
#(
    parameter int LOG_MAX   = 8,
    parameter int LEVEL_GAP = 4,
    localparam int LW       = $clog2(LOG_MAX + 1),
    localparam int GW       = (LEVEL_GAP > 1) ? $clog2(LEVEL_GAP) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LOG_MAX:0] min_side,
    input  logic             last_beat,
    output logic             scan_en,
    output logic             clr_pos,
    output logic [LW-1:0]    side_log,
    output logic [LW-1:0]    level,
    output logic             busy,
    output logic             done
);

    typedef struct packed {
        ps_state_e        state;
        logic [LW-1:0]    level;
        logic [LW-1:0]    slog;
        logic [LOG_MAX:0] min;
        logic [GW-1:0]    gap;
        logic             done;
    } lvl_t;

    lvl_t st_d, st_q;

    logic [LOG_MAX:0] half_side;
    logic             go_on;

    always_comb begin
        half_side = (LOG_MAX+1)'(1) << (st_q.slog - LW'(1));
        go_on     = (st_q.slog > LW'(1)) && (half_side >= st_q.min);

        st_d      = st_q;
        st_d.done = 1'b0;
        unique case (st_q.state)
            PS_IDLE: begin
                if (start) begin
                    st_d.state = PS_SCAN;
                    st_d.level = '0;
                    st_d.slog  = LW'(LOG_MAX);
                    st_d.min   = min_side;
                end
            end
            PS_SCAN: begin
                if (last_beat) begin
                    if (go_on) begin
                        st_d.state = PS_GAP;
                        st_d.level = st_q.level + LW'(1);
                        st_d.slog  = st_q.slog - LW'(1);
                        st_d.gap   = GW'(LEVEL_GAP - 1);
                    end else begin
                        st_d.state = PS_IDLE;
                        st_d.done  = 1'b1;
                    end
                end
            end
            PS_GAP: begin
                if (st_q.gap == '0) begin
                    st_d.state = PS_SCAN;
                end else begin
                    st_d.gap = st_q.gap - GW'(1);
                end
            end
            default: st_d.state = PS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state <= PS_IDLE;
            st_q.level <= '0;
            st_q.slog  <= LW'(LOG_MAX);
            st_q.min   <= '0;
            st_q.gap   <= '0;
            st_q.done  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign scan_en  = (st_q.state == PS_SCAN);
    assign clr_pos  = (st_q.state == PS_IDLE);
    assign side_log = st_q.slog;
    assign level    = st_q.level;
    assign busy     = (st_q.state != PS_IDLE);
    assign done     = st_q.done;

endmodule

// File: rtl/pairscan_ctrl.sv
// Paired even/odd row scan sequencer, multi-level.
module pairscan_ctrl #(
    parameter int SIDE_MAX  = 256,
    parameter int LEVEL_GAP = 4,
    localparam int LOG_MAX  = $clog2(SIDE_MAX),
    localparam int AW       = 2 * LOG_MAX,
    localparam int LW       = $clog2(LOG_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LOG_MAX:0] min_side,
    output logic             pix_valid,
    output logic [AW-1:0]    even_addr,
    output logic [AW-1:0]    odd_addr,
    output logic             row_first,
    output logic             row_last,
    output logic [LW-1:0]    cur_level,
    output logic             from_ll,
    output logic             busy,
    output logic             frame_done
);

    logic               scan_en;
    logic               clr_pos;
    logic [LW-1:0]      side_log;
    logic [LW-1:0]      level;
    logic [LOG_MAX-1:0] col;
    logic [LOG_MAX-2:0] pair;
    logic               first_col;
    logic               last_col;
    logic               last_beat;

    pairscan_level #(
        .LOG_MAX   (LOG_MAX),
        .LEVEL_GAP (LEVEL_GAP)
    ) u_level (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .min_side  (min_side),
        .last_beat (last_beat),
        .scan_en   (scan_en),
        .clr_pos   (clr_pos),
        .side_log  (side_log),
        .level     (level),
        .busy      (busy),
        .done      (frame_done)
    );

    pairscan_pos #(
        .LOG_MAX (LOG_MAX)
    ) u_pos (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr_pos),
        .adv       (scan_en),
        .side_log  (side_log),
        .col       (col),
        .pair      (pair),
        .first_col (first_col),
        .last_col  (last_col),
        .last_beat (last_beat)
    );

    pairscan_addr #(
        .LOG_MAX (LOG_MAX)
    ) u_addr (
        .col       (col),
        .pair      (pair),
        .side_log  (side_log),
        .even_addr (even_addr),
        .odd_addr  (odd_addr)
    );

    assign pix_valid = scan_en;
    assign row_first = scan_en && first_col;
    assign row_last  = scan_en && last_col;
    assign cur_level = level;
    assign from_ll   = (level != '0);

endmodule

// File: rtl/pairscan_ctrl_chk.sv
module pairscan_ctrl_chk #(
    parameter int SIDE_MAX = 256,
    localparam int LOG_MAX = $clog2(SIDE_MAX),
    localparam int AW      = 2 * LOG_MAX,
    localparam int LW      = $clog2(LOG_MAX + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          pix_valid,
    input logic [AW-1:0] even_addr,
    input logic [AW-1:0] odd_addr,
    input logic          row_first,
    input logic          row_last,
    input logic [LW-1:0] cur_level,
    input logic          busy,
    input logic          frame_done
);

    logic [AW-1:0] side_c;
    assign side_c = AW'(SIDE_MAX) >> cur_level;

    AST_ODD_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> (odd_addr - even_addr) == side_c); // R3

    AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && !row_last |=> pix_valid && (even_addr == $past(even_addr) + AW'(1))); // R4

    AST_FIRST_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && row_first |-> (even_addr & (side_c - AW'(1))) == '0); // R5

    AST_LAST_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid && row_last |-> (even_addr & (side_c - AW'(1))) == (side_c - AW'(1))); // R5

    AST_VALID_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> busy); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done); // R8

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !busy && !pix_valid); // R8

    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start |=> pix_valid && (even_addr == '0) && (cur_level == '0)); // R2

endmodule

bind pairscan_ctrl pairscan_ctrl_chk #(.SIDE_MAX(SIDE_MAX)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .pix_valid  (pix_valid),
    .even_addr  (even_addr),
    .odd_addr   (odd_addr),
    .row_first  (row_first),
    .row_last   (row_last),
    .cur_level  (cur_level),
    .busy       (busy),
    .frame_done (frame_done)
);

// File: tb/pairscan_ctrl_test.sv
module pairscan_ctrl_test;

    localparam int N    = 16;
    localparam int GAP  = 3;
    localparam int LOG  = $clog2(N);
    localparam int MW   = LOG + 1;
    localparam int AW   = 2 * LOG;
    localparam int LW   = $clog2(LOG + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [MW-1:0] min_side = '0;
    logic          pix_valid;
    logic [AW-1:0] even_addr;
    logic [AW-1:0] odd_addr;
    logic          row_first;
    logic          row_last;
    logic [LW-1:0] cur_level;
    logic          from_ll;
    logic          busy;
    logic          frame_done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pairscan_ctrl #(.SIDE_MAX(N), .LEVEL_GAP(GAP)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .min_side   (min_side),
        .pix_valid  (pix_valid),
        .even_addr  (even_addr),
        .odd_addr   (odd_addr),
        .row_first  (row_first),
        .row_last   (row_last),
        .cur_level  (cur_level),
        .from_ll    (from_ll),
        .busy       (busy),
        .frame_done (frame_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic bit next_level(input int s, input int mn);
        return (s / 2 >= mn) && (s / 2 >= 2);
    endfunction

    task automatic run_frame(input int mn, input bit noise);
        int s;
        int lvl;
        bit fin;
        @(negedge clk);
        min_side = MW'(mn);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        s = N;
        lvl = 0;
        fin = 1'b0;
        while (!fin) begin
            for (int p = 0; p < s / 2; p++) begin
                for (int c = 0; c < s; c++) begin
                    int ee;
                    ee = 2 * p * s + c;
                    // R2 R4 R6 R9 R10: beat present with expected position
                    chk(pix_valid === 1'b1, "R6 valid beat", int'(pix_valid), 1);
                    chk(int'(even_addr) == ee, noise ? "R3 R4 R9 R10 even_addr" : "R3 R2 even_addr",
                        int'(even_addr), ee);
                    chk(int'(odd_addr) == ee + s, "R3 odd_addr", int'(odd_addr), ee + s);
                    chk(row_first == (c == 0) && row_last == (c == s - 1), "R5 row strobes",
                        int'({row_first, row_last}), int'({c == 0, c == s - 1}));
                    chk(int'(cur_level) == lvl && from_ll == (lvl != 0), "R7 level/source",
                        int'({cur_level, from_ll}), (lvl << 1) | int'(lvl != 0));
                    start = noise && ($urandom % 37 == 0);
                    if (noise) min_side = MW'($urandom % (N + 4));
                    @(negedge clk);
                end
            end
            start = 1'b0;
            if (next_level(s, mn)) begin
                for (int g = 0; g < GAP; g++) begin
                    chk(!pix_valid && busy, "R7 gap cycle", int'({pix_valid, busy}), 1);
                    start = noise && ($urandom % 2 == 0);
                    @(negedge clk);
                end
                start = 1'b0;
                s = s / 2;
                lvl++;
            end else begin
                chk(frame_done && !busy && !pix_valid, "R8 done pulse",
                    int'({frame_done, busy, pix_valid}), 4);
                @(negedge clk);
                chk(!frame_done && !busy, "R8 done single cycle",
                    int'({frame_done, busy}), 0);
                fin = 1'b1;
            end
        end
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5eed_1234);
        repeat (3) @(negedge clk);
        chk(!pix_valid && !busy && !frame_done, "R1 reset state",
            int'({pix_valid, busy, frame_done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!pix_valid && !busy && !frame_done, "R1 idle after reset",
            int'({pix_valid, busy, frame_done}), 0);

        run_frame(N, 1'b0);       // R8 single level
        run_frame(0, 1'b0);       // R7 R8 down to side 2
        run_frame(N + 1, 1'b0);   // R8 minimum above full side
        run_frame(4, 1'b0);       // R8 stop at side 4
        run_frame(8, 1'b1);       // R9 R10 under noise
        for (int k = 0; k < 10; k++) begin
            run_frame(int'($urandom % (N + 2)), 1'b1);
        end
        repeat (2) @(negedge clk);
        chk(!pix_valid && !busy, "R9 stays idle without start",
            int'({pix_valid, busy}), 0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL R6 watchdog actual=%0d expected=%0d", 60000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule